// File: doc/BRIEF.md
# Fixed-Point PID Loop Core

This block is a sample-driven, fixed-point PID controller. Each time a `tick` pulse arrives it captures a setpoint, a process value, a manual command and the whole coefficient set, then one clock later presents a bounded control output together with a one-cycle `out_valid` strobe. The proportional path uses a weighted setpoint and the derivative path uses a second weighted setpoint. The derivative passes through a first-order low-pass filter.

The summed command is clamped to a programmable window, and a saturation flag reports when the clamp acts. Integrator wind-up is limited by one of two policies selected at run time. The first freezes the integrator while the error pushes further into the clamp. The second feeds the clamp excess back through a tracking gain. In manual mode the output follows the manual command, and the integrator is realigned to that command. The first automatic sample after manual mode reproduces the last manual output, so the output does not jump. The integrator state and a saturating count of clamped samples are exported for diagnostics.

All signals are signed two's complement with `FRAC` fraction bits. A product `a*b` is formed at full width, shifted right arithmetically by `FRAC` (rounding toward minus infinity), and then saturated to `W` bits. In the text below, sat(x) means saturation to `W` bits and isat(x) means saturation to the `W+GUARD`-bit integrator range.

Top module: `pid_loop_core`

## Requirements
- R1: While `rst` is high at a rising edge, and after that edge, `u_out`, `out_valid`, `sat`, `integ` and `sat_count` are all zero.
- R2: A `tick` sampled high while the core is idle is accepted. `out_valid` is then high for exactly the cycle after the next rising edge, and outputs update at that same edge. A `tick` sampled in the cycle right after an accepted one is ignored.
- R3: The proportional term is P = kp*sat(p_wt*sp − pv).
- R4: The derivative path uses ed = sat(d_wt*sp − pv) and dr = sat(ed − ed_prev). The filter update is df' = sat(df + d_alpha*sat(dr − df)), and the term is D = kd*df'. ed_prev and df start at zero and are updated on every sample, in both modes.
- R5: The integral path uses e = sat(sp − pv) and is exported on `integ`, which is `W+GUARD` bits wide and saturates to that range. In automatic mode with no clamp action, integ' = isat(I + ki*e).
- R6: In automatic mode raw = P + I + D. `u_out` is raw clamped to [`u_min`, `u_max`], and `sat` is 1 exactly when raw lies outside that window. `u_min` ≤ `u_max` is assumed.
- R7: When `aw_backcalc` = 0 (conditional integration), the integrator holds its value when raw > `u_max` with e > 0, or when raw < `u_min` with e < 0.
- R8: When `aw_backcalc` = 1 (back-calculation), integ' = isat(I + ki*e + k_track*sat(u_out − raw)).
- R9: When `manual` = 1, `u_out` is `u_man` clamped to the window and `sat` flags a clamped command. The integrator is set to isat(u_out − P − D).
- R10: On the first automatic sample after a manual sample, the integrator used is isat(previous u_out − P − D). The first automatic output therefore equals the last manual output.
- R11: All inputs and coefficients are captured only on an accepted `tick`. Changes made afterwards do not affect that sample's output.
- R12: `sat_count` increments on each sample that has `sat` = 1 and holds at its all-ones maximum. `sat_clr` high at an edge clears it, and a clear wins over an increment at the same edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick | input | 1 | Sample request pulse |
| manual | input | 1 | 1 = manual mode, 0 = automatic |
| aw_backcalc | input | 1 | Anti-windup policy: 1 = back-calculation, 0 = conditional integration |
| sat_clr | input | 1 | Clears the saturation counter |
| sp | input | W | Setpoint |
| pv | input | W | Process value |
| u_man | input | W | Manual output command |
| kp | input | W | Proportional gain |
| ki | input | W | Integral gain per sample |
| kd | input | W | Derivative gain per sample |
| p_wt | input | W | Setpoint weight for the proportional path |
| d_wt | input | W | Setpoint weight for the derivative path |
| d_alpha | input | W | Derivative low-pass coefficient |
| k_track | input | W | Back-calculation tracking gain |
| u_min | input | W | Lower output limit |
| u_max | input | W | Upper output limit |
| u_out | output | W | Control output |
| out_valid | output | 1 | One-cycle strobe marking a new output |
| sat | output | 1 | Clamp was active on the last sample |
| integ | output | W+GUARD | Integrator state |
| sat_count | output | CNTW | Saturating count of clamped samples |

## Verification
The bench builds the core with W=24, FRAC=8, GUARD=4 and CNTW=4. With these values every product fits a 64-bit reference model, and an output window of a few thousand LSBs is easy to drive into either clamp. The 4-bit counter reaches its all-ones ceiling after fifteen clamped samples. Back-calculation and conditional integration are each run into a known clamp, where the integrator values can be worked out by hand. A manual stretch that ends at zero command shows whether the next automatic sample keeps the output unchanged.

// File: rtl/pid_loop_core.sv
module pid_loop_core #(
  parameter int W     = 32,
  parameter int FRAC  = 16,
  parameter int GUARD = 4,
  parameter int CNTW  = 16
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    tick,
  input  logic                    manual,
  input  logic                    aw_backcalc,
  input  logic                    sat_clr,
  input  logic signed [W-1:0]     sp,
  input  logic signed [W-1:0]     pv,
  input  logic signed [W-1:0]     u_man,
  input  logic signed [W-1:0]     kp,
  input  logic signed [W-1:0]     ki,
  input  logic signed [W-1:0]     kd,
  input  logic signed [W-1:0]     p_wt,
  input  logic signed [W-1:0]     d_wt,
  input  logic signed [W-1:0]     d_alpha,
  input  logic signed [W-1:0]     k_track,
  input  logic signed [W-1:0]     u_min,
  input  logic signed [W-1:0]     u_max,
  output logic signed [W-1:0]     u_out,
  output logic                    out_valid,
  output logic                    sat,
  output logic signed [W+GUARD-1:0] integ,
  output logic [CNTW-1:0]         sat_count
);

  localparam int IW = W + GUARD;
  localparam int XW = 2*W + GUARD + 4;
  localparam logic signed [XW-1:0] WMAX = {{(XW-W+1){1'b0}}, {(W-1){1'b1}}};
  localparam logic signed [XW-1:0] WMIN = {{(XW-W+1){1'b1}}, {(W-1){1'b0}}};
  localparam logic signed [XW-1:0] IMAX = {{(XW-IW+1){1'b0}}, {(IW-1){1'b1}}};
  localparam logic signed [XW-1:0] IMIN = {{(XW-IW+1){1'b1}}, {(IW-1){1'b0}}};

  function automatic logic signed [XW-1:0] xw(input logic signed [W-1:0] a);
    return XW'(a);
  endfunction

  function automatic logic signed [XW-1:0] xi(input logic signed [IW-1:0] a);
    return XW'(a);
  endfunction

  function automatic logic signed [W-1:0] satw(input logic signed [XW-1:0] x);
    if (x > WMAX) return WMAX[W-1:0];
    if (x < WMIN) return WMIN[W-1:0];
    return x[W-1:0];
  endfunction

  function automatic logic signed [IW-1:0] sati(input logic signed [XW-1:0] x);
    if (x > IMAX) return IMAX[IW-1:0];
    if (x < IMIN) return IMIN[IW-1:0];
    return x[IW-1:0];
  endfunction

  function automatic logic signed [W-1:0] mulq(input logic signed [W-1:0] a,
                                               input logic signed [W-1:0] b);
    logic signed [2*W-1:0] pr;
    pr = (2*W)'(a) * (2*W)'(b);
    return satw(XW'(pr >>> FRAC));
  endfunction

  logic                 busy, vld_q, sat_q, manual_q, bc_q, was_man;
  logic signed [W-1:0]  sp_q, pv_q, man_q, kp_q, ki_q, kd_q, pw_q, dw_q, al_q, kt_q;
  logic signed [W-1:0]  umin_q, umax_q, u_q, edp_q, df_q;
  logic signed [IW-1:0] integ_q;
  logic [CNTW-1:0]      cnt_q;

  logic signed [W-1:0]  e, ep, ed, dr, df_n, p_t, d_t, ki_t, bc_t, u_cl;
  logic signed [IW-1:0] i_eff, integ_n;
  logic signed [XW-1:0] u_raw;
  logic                 hi, lo, hold;

  assign e     = satw(xw(sp_q) - xw(pv_q));
  assign ep    = satw(xw(mulq(pw_q, sp_q)) - xw(pv_q));
  assign ed    = satw(xw(mulq(dw_q, sp_q)) - xw(pv_q));
  assign dr    = satw(xw(ed) - xw(edp_q));
  assign df_n  = satw(xw(df_q) + xw(mulq(al_q, satw(xw(dr) - xw(df_q)))));
  assign p_t   = mulq(kp_q, ep);
  assign d_t   = mulq(kd_q, df_n);
  assign i_eff = was_man ? sati(xw(u_q) - xw(p_t) - xw(d_t)) : integ_q;
  assign u_raw = manual_q ? xw(man_q) : xw(p_t) + xi(i_eff) + xw(d_t);
  assign hi    = u_raw > xw(umax_q);
  assign lo    = u_raw < xw(umin_q);
  assign u_cl  = hi ? umax_q : (lo ? umin_q : u_raw[W-1:0]);
  assign ki_t  = mulq(ki_q, e);
  assign bc_t  = mulq(kt_q, satw(xw(u_cl) - u_raw));
  assign hold  = (hi && !e[W-1] && (e != '0)) || (lo && e[W-1]);

  always_comb begin
    if (manual_q)
      integ_n = sati(xw(u_cl) - xw(p_t) - xw(d_t));
    else if (bc_q)
      integ_n = sati(xi(i_eff) + xw(ki_t) + xw(bc_t));
    else if (hold)
      integ_n = i_eff;
    else
      integ_n = sati(xi(i_eff) + xw(ki_t));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0; vld_q <= 1'b0; sat_q <= 1'b0; manual_q <= 1'b0;
      bc_q <= 1'b0; was_man <= 1'b0;
      sp_q <= '0; pv_q <= '0; man_q <= '0; kp_q <= '0; ki_q <= '0; kd_q <= '0;
      pw_q <= '0; dw_q <= '0; al_q <= '0; kt_q <= '0; umin_q <= '0; umax_q <= '0;
      u_q <= '0; edp_q <= '0; df_q <= '0; integ_q <= '0; cnt_q <= '0;
    end else begin
      vld_q <= 1'b0;
      if (tick && !busy) begin
        busy <= 1'b1;
        sp_q <= sp; pv_q <= pv; man_q <= u_man; manual_q <= manual; bc_q <= aw_backcalc;
        kp_q <= kp; ki_q <= ki; kd_q <= kd; pw_q <= p_wt; dw_q <= d_wt;
        al_q <= d_alpha; kt_q <= k_track; umin_q <= u_min; umax_q <= u_max;
      end
      if (busy) begin
        busy    <= 1'b0;
        vld_q   <= 1'b1;
        u_q     <= u_cl;
        sat_q   <= hi || lo;
        integ_q <= integ_n;
        edp_q   <= ed;
        df_q    <= df_n;
        was_man <= manual_q;
      end
      if (sat_clr)
        cnt_q <= '0;
      else if (busy && (hi || lo) && !(&cnt_q))
        cnt_q <= cnt_q + CNTW'(1);
    end
  end

  assign u_out     = u_q;
  assign out_valid = vld_q;
  assign sat       = sat_q;
  assign integ     = integ_q;
  assign sat_count = cnt_q;

  AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (rst) out_valid |=> !out_valid); // R2
  AST_VALID_FROM_TICK: assert property (@(posedge clk) disable iff (rst) out_valid |-> $past(tick, 2)); // R2
  AST_OUT_IN_WINDOW: assert property (@(posedge clk) disable iff (rst) (out_valid && umin_q <= umax_q) |-> (u_out >= umin_q && u_out <= umax_q)); // R6
  AST_SAT_AT_EDGE: assert property (@(posedge clk) disable iff (rst) (out_valid && sat) |-> (u_out == umin_q || u_out == umax_q)); // R6
  AST_MANUAL_FOLLOW: assert property (@(posedge clk) disable iff (rst) (out_valid && manual_q && man_q >= umin_q && man_q <= umax_q) |-> (u_out == man_q && !sat)); // R9
  AST_COUNT_ADVANCES: assert property (@(posedge clk) disable iff (rst) (out_valid && sat) |-> (sat_count != '0 || $past(sat_clr))); // R12

endmodule

// File: tb/test_pid_loop_core.sv
`timescale 1ns/1ps
module test_pid_loop_core;
  localparam int W = 24, FRAC = 8, GUARD = 4, CNTW = 4;
  localparam int IW = W + GUARD;
  localparam int NV = 16;
  localparam longint VSP [NV] = '{2560, 2560, 2560, 2560, 2560, -1280, -1280, 0, 256, 512, 512, 512, 5000, 100, 0, 768};
  localparam longint VPV [NV] = '{0, 512, 1280, 2304, 2560, 2560, -256, 0, 0, 100, 100, 300, -5000, 200, 0, 0};
  localparam longint VMAN[NV] = '{0, 0, 0, 0, 0, 0, 0, 3000, 1500, -700, 0, 0, 0, 0, 0, 0};
  localparam bit     VMOD[NV] = '{0, 0, 0, 0, 0, 0, 0, 1, 1, 1, 0, 0, 0, 0, 1, 0};

  logic clk = 0, rst = 1, tick = 0, manual = 0, aw_backcalc = 0, sat_clr = 0;
  logic signed [W-1:0] sp = 0, pv = 0, u_man = 0, kp = 0, ki = 0, kd = 0;
  logic signed [W-1:0] p_wt = 0, d_wt = 0, d_alpha = 0, k_track = 0, u_min = 0, u_max = 0;
  logic signed [W-1:0] u_out;
  logic out_valid, sat;
  logic signed [IW-1:0] integ;
  logic [CNTW-1:0] sat_count;

  int ntests = 0, nfail = 0;
  bit done = 0;
  longint m_int, m_edp, m_df, m_u, m_cnt, exp_u, exp_int;
  bit m_was, exp_sat;

  always #2 clk = ~clk;

  pid_loop_core #(.W(W), .FRAC(FRAC), .GUARD(GUARD), .CNTW(CNTW)) i_pid_loop_core (
    .clk(clk), .rst(rst), .tick(tick), .manual(manual), .aw_backcalc(aw_backcalc),
    .sat_clr(sat_clr), .sp(sp), .pv(pv), .u_man(u_man), .kp(kp), .ki(ki), .kd(kd),
    .p_wt(p_wt), .d_wt(d_wt), .d_alpha(d_alpha), .k_track(k_track), .u_min(u_min),
    .u_max(u_max), .u_out(u_out), .out_valid(out_valid), .sat(sat), .integ(integ),
    .sat_count(sat_count));

  function automatic longint satb(longint x, int b);
    longint lim = longint'(1) <<< (b - 1);
    if (x > lim - 1) return lim - 1;
    if (x < -lim) return -lim;
    return x;
  endfunction

  function automatic longint mq(longint a, longint b);
    return satb((a * b) >>> FRAC, W);
  endfunction

  task automatic chk(input string req, input longint act, input longint exp);
    ntests++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic model_reset();
    m_int = 0; m_edp = 0; m_df = 0; m_u = 0; m_cnt = 0; m_was = 0;
  endtask

  task automatic model_step(input longint s, input longint p, input longint m, input bit mm);
    longint e, ep, ed, dr, dfn, pt, dt, ie, raw, ucl, lo_l, hi_l;
    bit h, l;
    lo_l = longint'(u_min); hi_l = longint'(u_max);
    e   = satb(s - p, W);
    ep  = satb(mq(longint'(p_wt), s) - p, W);
    ed  = satb(mq(longint'(d_wt), s) - p, W);
    dr  = satb(ed - m_edp, W);
    dfn = satb(m_df + mq(longint'(d_alpha), satb(dr - m_df, W)), W);
    pt  = mq(longint'(kp), ep);
    dt  = mq(longint'(kd), dfn);
    ie  = m_was ? satb(m_u - pt - dt, IW) : m_int;
    raw = mm ? m : pt + ie + dt;
    h = raw > hi_l; l = raw < lo_l;
    ucl = h ? hi_l : (l ? lo_l : raw);
    if (mm) m_int = satb(ucl - pt - dt, IW);
    else if (aw_backcalc) m_int = satb(ie + mq(longint'(ki), e) + mq(longint'(k_track), satb(ucl - raw, W)), IW);
    else if ((h && e > 0) || (l && e < 0)) m_int = ie;
    else m_int = satb(ie + mq(longint'(ki), e), IW);
    m_edp = ed; m_df = dfn; m_was = mm; m_u = ucl;
    if ((h || l) && m_cnt < 15) m_cnt++;
    exp_u = ucl; exp_sat = h || l; exp_int = m_int;
  endtask

  task automatic do_sample(input longint s, input longint p, input longint m, input bit mm,
                           input string req, input bit chg_kp, input bit dbl);
    @(negedge clk);
    sp = W'(s); pv = W'(p); u_man = W'(m); manual = mm; tick = 1;
    model_step(s, p, m, mm);
    @(negedge clk);
    tick = dbl;
    if (chg_kp) kp = 0;
    @(negedge clk);
    tick = 0;
    chk({req, " R2 valid"}, out_valid, 1);
    chk({req, " u_out"}, longint'(u_out), exp_u);
    chk({req, " R6 sat"}, sat, exp_sat);
    chk({req, " R5 integ"}, longint'(integ), exp_int);
    chk({req, " R12 count"}, sat_count, m_cnt);
    @(negedge clk);
    chk({req, " R2 single strobe"}, out_valid, 0);
  endtask

  task automatic set_gains();
    kp = 256; ki = 64; kd = 128; p_wt = 128; d_wt = 0; d_alpha = 128;
    k_track = 128; u_min = -10000; u_max = 10000; aw_backcalc = 0;
  endtask

  task automatic do_reset();
    rst = 1; tick = 0; sat_clr = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    model_reset();
    @(negedge clk);
    chk("R1 u_out", longint'(u_out), 0);
    chk("R1 out_valid", out_valid, 0);
    chk("R1 sat", sat, 0);
    chk("R1 integ", longint'(integ), 0);
    chk("R1 sat_count", sat_count, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", ntests, nfail);
      $finish;
    end
  end

  initial begin
    longint prev_u;
    set_gains();
    do_reset();

    prev_u = 0;
    for (int i = 0; i < NV; i++) begin
      do_sample(VSP[i], VPV[i], VMAN[i], VMOD[i], (VMOD[i] ? "R9 table" : "R3 R4 table"), 0, 0);
      if (i > 0 && VMOD[i-1] && !VMOD[i])
        chk("R10 bumpless", longint'(u_out), prev_u);
      prev_u = longint'(u_out);
    end

    // conditional integration into both clamps (R7)
    do_reset();
    kp = 256; ki = 64; kd = 0; p_wt = 256; d_wt = 0; d_alpha = 128; k_track = 256;
    u_min = -1000; u_max = 1000; aw_backcalc = 0;
    for (int k = 0; k < 3; k++) begin
      do_sample(4000, 0, 0, 0, "R7 hold high", 0, 0);
      chk("R7 integ frozen high", longint'(integ), 0);
      chk("R6 clamp high", longint'(u_out), 1000);
    end
    do_sample(-4000, 0, 0, 0, "R7 hold low", 0, 0);
    chk("R7 integ frozen low", longint'(integ), 0);
    chk("R6 clamp low", longint'(u_out), -1000);

    // back-calculation (R8)
    aw_backcalc = 1;
    do_sample(4000, 0, 0, 0, "R8 backcalc", 0, 0);
    chk("R8 integ after first", longint'(integ), -2000);
    do_sample(4000, 0, 0, 0, "R8 backcalc steady", 0, 0);
    chk("R8 integ steady", longint'(integ), -2000);

    // counter ceiling and clear (R12)
    for (int k = 0; k < 12; k++) do_sample(4000, 0, 0, 0, "R12 fill", 0, 0);
    chk("R12 count ceiling", sat_count, 15);
    @(negedge clk); sat_clr = 1;
    @(negedge clk); sat_clr = 0; m_cnt = 0;
    chk("R12 cleared", sat_count, 0);

    // coefficient captured at tick (R11), tick while busy ignored (R2)
    set_gains();
    do_sample(1000, 200, 0, 0, "R11 latch", 1, 0);
    kp = 256;
    do_sample(1000, 200, 0, 0, "R2 double tick", 0, 1);
    chk("R11 no extra sample", sat_count, m_cnt);

    // derivative filter step response (R4), weighting only on P (R3)
    kp = 0; ki = 0; kd = 256; d_wt = 0; d_alpha = 128; aw_backcalc = 0;
    do_sample(0, 0, 0, 0, "R4 settle", 0, 0);
    do_sample(0, -1024, 0, 0, "R4 pv step", 0, 0);
    do_sample(0, -1024, 0, 0, "R4 decay", 0, 0);
    kp = 256; kd = 0; p_wt = 128;
    do_sample(2048, 0, 0, 0, "R3 weighted", 0, 0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", ntests, nfail);
    $finish;
  end
endmodule